// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block carries 36-bit words in one direction between two clocks. The two clocks are free-running. They may be unrelated, or they may be one and the same clock. The writer pushes a word on any write-clock edge where it asks to write and the block shows room. The reader finds the oldest word already waiting in an output register. That word loads itself as soon as it is known on the read side, and each accepted read brings the next word forward in the same edge.

Each side only sees flags timed by its own clock. The write side has a ready flag and a nearly-full flag. The read side has a data-valid flag and a nearly-empty flag. Pointers cross between the domains in Gray code through two-flop chains. The nearly-full and nearly-empty thresholds come from a two-bit code, which is sampled while reset is held and frozen when reset is released.

Top module: `xcf_fifo`

## Requirements
- R1: After `rst` has been high for at least four edges of each clock and then low for six edges of each, `in_rdy` is 1, `out_rdy` is 0, `almost_empty` is 1 and `almost_full` is 0.
- R2: Words leave in the order they were accepted. Exactly one word is consumed per read-clock edge where `rd_en` and `out_rdy` are both high.
- R3: With one shared clock, a word written into an empty FIFO raises `out_rdy` on the third clock edge after the write edge, not before.
- R4: The word that raises `out_rdy` is already on `rd_data` in that same cycle, without any `rd_en`.
- R5: `rd_en` while `out_rdy` is low has no effect. While `out_rdy` is high and `rd_en` is low, `out_rdy` and `rd_data` hold.
- R6: A write takes effect only when `wr_en` and `in_rdy` are both high. `in_rdy` drops once the memory holds DEPTH words, so the block stores at most DEPTH+1 words, counting the output register.
- R7: `almost_full` is high when the number of free memory locations is at most the margin. This count is DEPTH minus the words in memory, and the output register is not counted.
- R8: `almost_empty` is high when the stored words, memory plus the output register, number at most the margin.
- R9: The margin comes from `margin_sel` as last sampled while reset is held: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 64. Changes to `margin_sel` after release are ignored.
- R10: With one shared clock, a write and a read on the same edge both take effect, and the stream stays intact.
- R11: With unrelated clocks of either speed ratio, every word arrives once, in order, and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Active-high reset, held for at least four edges of each clock |
| margin_sel | input | 2 | Threshold code, sampled during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to write |
| in_rdy | output | 1 | Room in memory (write clock) |
| almost_full | output | 1 | Free locations at or below the margin (write clock) |
| rd_en | input | 1 | Read request; consumes the shown word |
| rd_data | output | 36 | Output register |
| out_rdy | output | 1 | Output register holds a valid word (read clock) |
| almost_empty | output | 1 | Stored words at or below the margin (read clock) |

## Verification
With one shared clock, a write and a read can land on the same edge. The same edge can also both consume the shown word and pull the next one into the output register. The bench provokes these by streaming, with the writer driving `wr_en` whenever `in_rdy` is high and the reader driving `rd_en` whenever `out_rdy` is high. It counts edges where both a write and a read are accepted. It judges the run by the order of every word and by the FIFO being empty afterwards. Fill and drain sweeps are run one word at a time for every margin code, and each flag is compared with counts computed in the bench.

// File: rtl/xcf_pkg.sv
`timescale 1ns/1ps
package xcf_pkg;
    localparam int unsigned WORD_W = 36;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        MARGIN_4  = 2'd0,
        MARGIN_8  = 2'd1,
        MARGIN_16 = 2'd2,
        MARGIN_64 = 2'd3
    } margin_e;

    typedef struct packed {
        logic ready;
        logic near;
    } port_flags_t;

    function automatic logic [6:0] margin_words(margin_e m);
        case (m)
            MARGIN_4:  return 7'd4;
            MARGIN_8:  return 7'd8;
            MARGIN_16: return 7'd16;
            default:   return 7'd64;
        endcase
    endfunction
endpackage

// File: rtl/xcf_sync.sv
`timescale 1ns/1ps
module xcf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xcf_ram.sv
`timescale 1ns/1ps
module xcf_ram
    import xcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int CELLS = 1 << AW;

    word_t cells [CELLS];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/xcf_wr_ctl.sv
`timescale 1ns/1ps
module xcf_wr_ctl
    import xcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  margin_e       margin_sel,
    input  logic [AW:0]   rgray_s,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          wr_fire,
    output port_flags_t   flags
);
    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    logic [AW:0] wbin, wnext, rbin_s, used, free;
    margin_e     margin_q;

    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        used        = wbin - rbin_s;
        free        = DEPTH_V - used;
        flags.ready = !rst && (used != DEPTH_V);
        flags.near  = !rst && (free <= (AW+1)'(margin_words(margin_q)));
        wr_fire     = wr_en && flags.ready;
        wnext       = wbin + {{AW{1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin     <= '0;
            wgray    <= '0;
            margin_q <= margin_sel;
        end else if (wr_fire) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    assign waddr = wbin[AW-1:0];

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flags.ready) |=> $stable(wbin));
    a_r6_used_bound: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_V);
    a_r7_near_when_full: assert property (@(posedge clk) disable iff (rst)
        !flags.ready |-> flags.near);
    a_r2_gray_step: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> $countones(wgray ^ $past(wgray)) == 1);
endmodule

// File: rtl/xcf_rd_ctl.sv
`timescale 1ns/1ps
module xcf_rd_ctl
    import xcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  margin_e       margin_sel,
    input  logic [AW:0]   wgray_s,
    input  word_t         mem_word,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output word_t         rd_data,
    output port_flags_t   flags
);
    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    logic [AW:0]   rbin, rnext, wbin_s, avail;
    logic [AW+1:0] stored;
    logic          out_rdy, mem_ne, take, load;
    margin_e       margin_q;

    always_comb begin
        wbin_s[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        avail       = wbin_s - rbin;
        mem_ne      = (avail != '0);
        take        = rd_en && out_rdy;
        load        = mem_ne && (!out_rdy || take);
        rnext       = rbin + {{AW{1'b0}}, 1'b1};
        stored      = {1'b0, avail} + {{(AW+1){1'b0}}, out_rdy};
        flags.ready = out_rdy;
        flags.near  = stored <= (AW+2)'(margin_words(margin_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin     <= '0;
            rgray    <= '0;
            out_rdy  <= 1'b0;
            rd_data  <= '0;
            margin_q <= margin_sel;
        end else if (load) begin
            rd_data <= mem_word;
            rbin    <= rnext;
            rgray   <= rnext ^ (rnext >> 1);
            out_rdy <= 1'b1;
        end else if (take) begin
            out_rdy <= 1'b0;
        end
    end

    assign raddr = rbin[AW-1:0];

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (out_rdy && !rd_en) |=> (out_rdy && $stable(rd_data)));
    a_r5_no_phantom: assert property (@(posedge clk) disable iff (rst)
        (!out_rdy && !mem_ne) |=> !out_rdy);
    a_r8_near_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_rdy |-> flags.near);
    a_r2_rise_has_data: assert property (@(posedge clk) disable iff (rst)
        $rose(out_rdy) |-> $past(mem_ne));
    a_r6_avail_bound: assert property (@(posedge clk) disable iff (rst)
        avail <= DEPTH_V);
endmodule

// File: rtl/xcf_fifo.sv
`timescale 1ns/1ps
module xcf_fifo
    import xcf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic [1:0]        margin_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              in_rdy,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              out_rdy,
    output logic              almost_empty
);
    localparam int AW          = $clog2(DEPTH);
    localparam int SYNC_STAGES = 2;

    margin_e     sel_e;
    logic [1:0]  wrst_sh, rrst_sh;
    logic        wrst, rrst, wr_fire;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0] wgray, rgray, wgray_s, rgray_s;
    word_t       mem_word;
    port_flags_t wflags, rflags;

    assign sel_e = margin_e'(margin_sel);

    always_ff @(posedge wclk) wrst_sh <= {wrst_sh[0], rst};
    always_ff @(posedge rclk) rrst_sh <= {rrst_sh[0], rst};
    assign wrst = wrst_sh[1];
    assign rrst = rrst_sh[1];

    xcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s));
    xcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s));

    xcf_ram #(.AW(AW)) u_ram (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_word));

    xcf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wclk), .rst(wrst), .wr_en(wr_en), .margin_sel(sel_e),
        .rgray_s(rgray_s), .waddr(waddr), .wgray(wgray),
        .wr_fire(wr_fire), .flags(wflags));

    xcf_rd_ctl #(.AW(AW)) u_rd (
        .clk(rclk), .rst(rrst), .rd_en(rd_en), .margin_sel(sel_e),
        .wgray_s(wgray_s), .mem_word(mem_word), .raddr(raddr),
        .rgray(rgray), .rd_data(rd_data), .flags(rflags));

    assign in_rdy       = wflags.ready;
    assign almost_full  = wflags.near;
    assign out_rdy      = rflags.ready;
    assign almost_empty = rflags.near;

    a_r1_reset_flags: assert property (@(posedge rclk)
        rrst |=> (!out_rdy && almost_empty));
endmodule

// File: tb/xcf_fifo_bench.sv
`timescale 1ns/1ps
module xcf_fifo_bench;
    localparam int DEPTH = 256;

    logic        wclk = 1'b0, rclk_free = 1'b0, same_clk = 1'b1, rclk;
    realtime     rhalf = 13.5;
    logic        rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  margin_sel = 2'b00;
    logic [35:0] wr_data = '0, rd_data;
    logic        in_rdy, almost_full, out_rdy, almost_empty;
    int          checks = 0, fails = 0, both_cnt = 0;

    always #10 wclk = ~wclk;
    always #(rhalf) rclk_free = ~rclk_free;
    assign rclk = same_clk ? wclk : rclk_free;

    xcf_fifo #(.DEPTH(DEPTH)) u_xcf_fifo (
        .wclk(wclk), .rclk(rclk), .rst(rst), .margin_sel(margin_sel),
        .wr_en(wr_en), .wr_data(wr_data), .in_rdy(in_rdy),
        .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data),
        .out_rdy(out_rdy), .almost_empty(almost_empty));

    always @(posedge wclk)
        if (same_clk && wr_en && in_rdy && rd_en && out_rdy) both_cnt++;

    task automatic check_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] pat(int i);
        return {4'(i + 5), 32'(i) * 32'h9E37_79B1};
    endfunction

    function automatic int margin_of(int c);
        return (c == 0) ? 4 : (c == 1) ? 8 : (c == 2) ? 16 : 64;
    endfunction

    function automatic int free_of(int stored);
        return DEPTH - ((stored > 0) ? stored - 1 : 0);
    endfunction

    task automatic reset_fifo(int code);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; margin_sel = 2'(code);
        repeat (6) @(posedge wclk);
        repeat (6) @(posedge rclk);
        @(negedge wclk) rst = 1'b0;
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic push(input logic [35:0] d, output bit took);
        @(negedge wclk);
        took = in_rdy; wr_en = 1'b1; wr_data = d;
        @(negedge wclk) wr_en = 1'b0;
    endtask

    task automatic pop(output logic [35:0] d, output bit got);
        @(negedge rclk);
        got = out_rdy; d = rd_data; rd_en = 1'b1;
        @(negedge rclk) rd_en = 1'b0;
    endtask

    task automatic sweep(int code);
        int  acc = 0, off = margin_of(code);
        bit  took;
        logic [35:0] d;
        same_clk = (code < 2);
        reset_fifo(code);
        margin_sel = 2'(3 - code);                       // R9: must be ignored
        for (int n = 0; n <= DEPTH + 2; n++) begin
            if (n > 0) begin
                push(pat(acc), took);
                if (took) acc++;
            end
            settle();
            check_eq("R6 in_rdy", in_rdy, acc <= DEPTH);
            check_eq((acc == off || acc == off + 1) ? "R9 margin" : "R8 almost_empty",
                     almost_empty, acc <= off);
            check_eq("R7 almost_full", almost_full, free_of(acc) <= off);
        end
        check_eq("R6 capacity", acc, DEPTH + 1);
        for (int i = 0; i < acc; i++) begin
            pop(d, took);
            check_eq("R2 valid", took, 1);
            check_eq(same_clk ? "R2 order" : "R11 order", d, pat(i));
            settle();
            check_eq("R8 drain almost_empty", almost_empty, (acc - 1 - i) <= off);
            check_eq("R7 drain almost_full", almost_full, free_of(acc - 1 - i) <= off);
        end
        check_eq("R5 empty", out_rdy, 0);
    endtask

    task automatic stream(int count, int base, string tag);
        fork
            begin
                int wx = 0;
                while (wx < count) begin
                    @(negedge wclk);
                    if (in_rdy) begin wr_data = pat(base + wx); wr_en = 1'b1; wx++; end
                    else wr_en = 1'b0;
                end
                @(negedge wclk) wr_en = 1'b0;
            end
            begin
                int rx = 0;
                while (rx < count) begin
                    @(negedge rclk);
                    if (out_rdy) begin
                        check_eq(tag, rd_data, pat(base + rx));
                        rd_en = 1'b1; rx++;
                    end else rd_en = 1'b0;
                end
                @(negedge rclk) rd_en = 1'b0;
            end
        join
        settle();
        check_eq({tag, " drained"}, out_rdy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge wclk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [35:0] d;
        bit got;
        reset_fifo(0);
        check_eq("R1 in_rdy", in_rdy, 1);
        check_eq("R1 out_rdy", out_rdy, 0);
        check_eq("R1 almost_empty", almost_empty, 1);
        check_eq("R1 almost_full", almost_full, 0);

        // R3/R4: shared clock latency of the first word
        @(negedge wclk); wr_en = 1'b1; wr_data = pat(100);
        @(negedge wclk); wr_en = 1'b0;
        check_eq("R3 edge0", out_rdy, 0);
        @(negedge wclk) check_eq("R3 edge1", out_rdy, 0);
        @(negedge wclk) check_eq("R3 edge2", out_rdy, 0);
        @(negedge wclk) check_eq("R3 edge3", out_rdy, 1);
        check_eq("R4 fall-through", rd_data, pat(100));
        repeat (5) @(negedge wclk);
        check_eq("R5 hold valid", out_rdy, 1);
        check_eq("R5 hold data", rd_data, pat(100));
        pop(d, got);
        check_eq("R2 single read", d, pat(100));
        check_eq("R2 empty after read", out_rdy, 0);
        @(negedge rclk) rd_en = 1'b1;                    // R5: read while empty
        repeat (3) @(negedge rclk);
        rd_en = 1'b0;
        check_eq("R5 empty read ignored", out_rdy, 0);
        push(pat(101), got);
        settle();
        check_eq("R5 next word intact", rd_data, pat(101));
        pop(d, got);

        for (int c = 0; c < 4; c++) sweep(c);

        same_clk = 1'b1;
        reset_fifo(1);
        both_cnt = 0;
        stream(300, 1000, "R10 same-edge order");
        check_eq("R10 same-edge events", both_cnt > 0, 1);

        same_clk = 1'b0; rhalf = 13.5;
        reset_fifo(2);
        stream(400, 3000, "R11 slow reader");
        rhalf = 6.5;
        reset_fifo(3);
        stream(400, 5000, "R11 fast reader");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule